// File: doc/BRIEF.md
# Half-Duplex GMII Transmit Controller

This block stands between a frame source and the byte-wide GMII transmit pins. After a start request it holds off while the medium is busy, meaning carrier sense or collision is high. It then passes the frame bytes through to the pins, with the source's error flag alongside each byte. After the last byte it can add a carrier-extension tail.

If carrier or collision appears while it is driving the medium, it drops enable and error in that same cycle and pulses an abort flag. It then waits for a quiet medium before it accepts another start request, so the user can choose to resend the frame. In full-duplex operation, carrier sense and collision are not looked at.

The tail length in bytes is sampled at the start request. So are an optional error-marking flag and the tail byte index at which the error code begins. The source holds no buffer: it must present a byte in every cycle in which the block asks for one.

Top module: `hdx_gmii_tx_ctrl`

## Requirements
- R1: With half_duplex_i=1, after an accepted start the block drives gtx_en_o=0 for as long as crs_i or col_i is high. It enters transmission on the clock edge that follows the first cycle in which both are low.
- R2: In every transmission cycle that is not aborted, gtx_en_o=1, gtxd_o equals src_data_i, gtx_er_o equals src_err_i and src_ready_o=1, all in that same cycle.
- R3: With half_duplex_i=1, if crs_i or col_i is high during a transmission or extension cycle, gtx_en_o and gtx_er_o are 0 in that same cycle, abort_o is 1 for exactly that one cycle, and both outputs stay 0 afterwards.
- R4: After an abort, start_ready_o stays 0 and start_i is ignored until a cycle in which crs_i and col_i are both low. start_ready_o is 1 from the next cycle on.
- R5: If the sampled tail length L is greater than 0, the L cycles that directly follow the last frame byte carry gtx_en_o=0, gtx_er_o=1 and gtxd_o=0x0F.
- R6: If ext_err_en_i was 1 at start, tail bytes with index k >= ext_err_at_i (counting from 0) carry 0x1F instead of 0x0F. Earlier tail bytes stay 0x0F.
- R7: A tail length of 0 adds no extension: the cycle after the last frame byte is idle.
- R8: done_o is a one-cycle pulse on the last driven cycle: the last frame byte when L=0, otherwise the last tail byte. It never coincides with abort_o.
- R9: With half_duplex_i=0, crs_i and col_i have no effect. Transmission starts on the edge after the start request's deferral cycle, and no frame is aborted.
- R10: During reset the block is idle: start_ready_o=1 and every other output is 0.
- R11: When idle, gtx_en_o=0, gtx_er_o=0 and gtxd_o=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_duplex_i | input | 1 | 1 = half duplex, 0 = full duplex |
| crs_i | input | 1 | Carrier sense from the PHY |
| col_i | input | 1 | Collision from the PHY |
| start_i | input | 1 | Request to send a frame, taken when start_ready_o=1 |
| ext_len_i | input | EXT_W | Tail length in bytes, sampled at start |
| ext_err_en_i | input | 1 | Mark part of the tail as errored, sampled at start |
| ext_err_at_i | input | EXT_W | First errored tail byte index, sampled at start |
| src_data_i | input | 8 | Frame byte from the source |
| src_err_i | input | 1 | Error flag for the current byte |
| src_last_i | input | 1 | Current byte is the final frame byte |
| src_ready_o | output | 1 | A source byte is consumed this cycle |
| gtx_en_o | output | 1 | GMII transmit enable |
| gtx_er_o | output | 1 | GMII transmit error |
| gtxd_o | output | 8 | GMII transmit data |
| abort_o | output | 1 | One-cycle pulse when a frame is cut short |
| done_o | output | 1 | One-cycle pulse on the last driven cycle |
| start_ready_o | output | 1 | Block is idle and will take start_i |

## Verification
On every cycle, the assertions check several orderings:
- transmit enable rises only after a quiet cycle;
- an abort is followed by silent pins and a closed start window;
- a frame with a tail moves straight into extension codes;
- 0x1F tail bytes are never followed by 0x0F;
- abort and done never coincide, and full duplex never aborts.

The exact byte values, the index at which the error code begins, the tail length and the point at which a retry becomes possible are shown only by the bench's scenarios. These mix random frames, deferrals and abort points with directed edge cases.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_TX,
    ST_EXTEND,
    ST_ABORTED
  } tx_state_e;

  localparam logic [7:0] CODE_EXT     = 8'h0F;
  localparam logic [7:0] CODE_EXT_ERR = 8'h1F;
  localparam logic [7:0] IDLE_BYTE    = 8'h00;
endpackage

// File: rtl/hdx_rst_sync.sv
module hdx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/hdx_medium_gate.sv
module hdx_medium_gate (
  input  logic half_i,
  input  logic crs_i,
  input  logic col_i,
  output logic busy_o
);
  always_comb begin
    busy_o = 1'b0;
    if (half_i) busy_o = crs_i | col_i;
  end
endmodule

// File: rtl/hdx_ext_counter.sv
module hdx_ext_counter #(
  parameter int EXT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             inc_i,
  input  logic [EXT_W-1:0] len_i,
  input  logic             err_en_i,
  input  logic [EXT_W-1:0] err_at_i,
  output logic             len_zero_o,
  output logic             last_o,
  output logic             err_zone_o
);
  logic [EXT_W-1:0] cnt_q, cnt_d;
  logic [EXT_W-1:0] len_q, len_d;
  logic [EXT_W-1:0] at_q, at_d;
  logic             een_q, een_d;
  logic             upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    at_d   = at_q;
    een_d  = een_q;
    upd_en = load_i | inc_i;
    if (load_i) begin
      cnt_d = '0;
      len_d = len_i;
      at_d  = err_at_i;
      een_d = err_en_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
      at_q  <= '0;
      een_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
      at_q  <= at_d;
      een_q <= een_d;
    end
  end

  assign len_zero_o = (len_q == '0);
  assign last_o     = (cnt_q == len_q - 1'b1);
  assign err_zone_o = een_q && (cnt_q >= at_q);

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (cnt_q < len_q));
endmodule

// File: rtl/hdx_tx_fsm.sv
module hdx_tx_fsm
  import hdx_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       busy_i,
  input  logic [7:0] src_data_i,
  input  logic       src_err_i,
  input  logic       src_last_i,
  input  logic       len_zero_i,
  input  logic       ext_last_i,
  input  logic       err_zone_i,
  output logic       load_o,
  output logic       inc_o,
  output logic       src_ready_o,
  output logic       gtx_en_o,
  output logic       gtx_er_o,
  output logic [7:0] gtxd_o,
  output logic       abort_o,
  output logic       done_o,
  output logic       start_ready_o
);
  tx_state_e st_q, st_d;
  logic      st_en;

  always_comb begin
    st_d        = st_q;
    load_o      = 1'b0;
    inc_o       = 1'b0;
    src_ready_o = 1'b0;
    gtx_en_o    = 1'b0;
    gtx_er_o    = 1'b0;
    gtxd_o      = IDLE_BYTE;
    abort_o     = 1'b0;
    done_o      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          st_d   = ST_DEFER;
        end
      end
      ST_DEFER: begin
        if (!busy_i) st_d = ST_TX;
      end
      ST_TX: begin
        if (busy_i) begin
          abort_o = 1'b1;
          st_d    = ST_ABORTED;
        end else begin
          gtx_en_o    = 1'b1;
          gtx_er_o    = src_err_i;
          gtxd_o      = src_data_i;
          src_ready_o = 1'b1;
          if (src_last_i) begin
            if (len_zero_i) begin
              done_o = 1'b1;
              st_d   = ST_IDLE;
            end else begin
              st_d = ST_EXTEND;
            end
          end
        end
      end
      ST_EXTEND: begin
        if (busy_i) begin
          abort_o = 1'b1;
          st_d    = ST_ABORTED;
        end else begin
          gtx_er_o = 1'b1;
          gtxd_o   = err_zone_i ? CODE_EXT_ERR : CODE_EXT;
          if (ext_last_i) begin
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            inc_o = 1'b1;
          end
        end
      end
      ST_ABORTED: begin
        if (!busy_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign start_ready_o = (st_q == ST_IDLE);

  // R1
  defer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gtx_en_o) |-> $past(!busy_i));
  // R3
  abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (!gtx_en_o && !gtx_er_o));
  // R4
  abort_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !start_ready_o);
  // R5
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gtx_en_o && src_last_i && !len_zero_i) |=> (busy_i || (gtx_er_o && !gtx_en_o)));
  // R6
  ext_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gtx_en_o && gtx_er_o && gtxd_o == CODE_EXT_ERR) |=> (!gtx_er_o || gtxd_o == CODE_EXT_ERR));
  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({abort_o, done_o}));
endmodule

// File: rtl/hdx_gmii_tx_ctrl.sv
module hdx_gmii_tx_ctrl #(
  parameter int EXT_W      = 4,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_duplex_i,
  input  logic             crs_i,
  input  logic             col_i,
  input  logic             start_i,
  input  logic [EXT_W-1:0] ext_len_i,
  input  logic             ext_err_en_i,
  input  logic [EXT_W-1:0] ext_err_at_i,
  input  logic [7:0]       src_data_i,
  input  logic             src_err_i,
  input  logic             src_last_i,
  output logic             src_ready_o,
  output logic             gtx_en_o,
  output logic             gtx_er_o,
  output logic [7:0]       gtxd_o,
  output logic             abort_o,
  output logic             done_o,
  output logic             start_ready_o
);
  logic srst_n;
  logic busy;
  logic load, inc, len_zero, ext_last, err_zone;

  hdx_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n_o(srst_n)
  );

  hdx_medium_gate u_gate (
    .half_i(half_duplex_i), .crs_i(crs_i), .col_i(col_i), .busy_o(busy)
  );

  hdx_ext_counter #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst_n(srst_n), .load_i(load), .inc_i(inc),
    .len_i(ext_len_i), .err_en_i(ext_err_en_i), .err_at_i(ext_err_at_i),
    .len_zero_o(len_zero), .last_o(ext_last), .err_zone_o(err_zone)
  );

  hdx_tx_fsm u_fsm (
    .clk(clk), .rst_n(srst_n), .start_i(start_i), .busy_i(busy),
    .src_data_i(src_data_i), .src_err_i(src_err_i), .src_last_i(src_last_i),
    .len_zero_i(len_zero), .ext_last_i(ext_last), .err_zone_i(err_zone),
    .load_o(load), .inc_o(inc), .src_ready_o(src_ready_o),
    .gtx_en_o(gtx_en_o), .gtx_er_o(gtx_er_o), .gtxd_o(gtxd_o),
    .abort_o(abort_o), .done_o(done_o), .start_ready_o(start_ready_o)
  );

  // R9
  full_dup_no_abort_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !half_duplex_i |-> !abort_o);
endmodule

// File: tb/hdx_gmii_tx_ctrl_tb_top.sv
module hdx_gmii_tx_ctrl_tb_top;
  localparam int EXT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             half, crs, col, start;
  logic [EXT_W-1:0] ext_len, ext_at;
  logic             ext_een;
  logic [7:0]       sdata;
  logic             serr, slast;
  logic             src_ready, gtx_en, gtx_er, abort_p, done_p, start_ready;
  logic [7:0]       gtxd;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hdx_gmii_tx_ctrl #(.EXT_W(EXT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_duplex_i(half), .crs_i(crs), .col_i(col),
    .start_i(start), .ext_len_i(ext_len), .ext_err_en_i(ext_een),
    .ext_err_at_i(ext_at), .src_data_i(sdata), .src_err_i(serr),
    .src_last_i(slast), .src_ready_o(src_ready), .gtx_en_o(gtx_en),
    .gtx_er_o(gtx_er), .gtxd_o(gtxd), .abort_o(abort_p), .done_o(done_p),
    .start_ready_o(start_ready)
  );

  function automatic logic [7:0] tail_code(bit een, int at, int k);
    return (een && k >= at) ? 8'h1F : 8'h0F;
  endfunction

  task automatic chk(input string tag, input bit en, input bit er, input logic [7:0] d,
                     input bit rdy, input bit ab, input bit dn, input bit sr);
    logic [13:0] act, exp;
    act = {gtx_en, gtx_er, gtxd, src_ready, abort_p, done_p, start_ready};
    exp = {en, er, d, rdy, ab, dn, sr};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (en,er,data,rdy,abort,done,start_rdy)",
               tag, act, exp);
    end
  endtask

  // Entered just after a falling edge, leaves just after a falling edge.
  task automatic run_frame(input bit hd, input int nb, input int len, input bit een,
                           input int at, input int dly, input int ab_at, input int qa);
    bit aborted = 0;
    half = hd; crs = 0; col = 0; slast = 0; serr = 0;
    start = 1; ext_len = len[EXT_W-1:0]; ext_een = een; ext_at = at[EXT_W-1:0];
    #1 chk("R11 idle at start request", 0, 0, 8'h00, 0, 0, 0, 1);
    @(negedge clk);
    start = 0;
    if (hd) begin
      for (int k = 0; k < dly; k++) begin
        crs = k[0]; col = ~k[0];
        #1 chk("R1 deferring while medium busy", 0, 0, 8'h00, 0, 0, 0, 0);
        @(negedge clk);
      end
      crs = 0; col = 0;
      #1 chk("R1 quiet deferral cycle", 0, 0, 8'h00, 0, 0, 0, 0);
      @(negedge clk);
    end else begin
      crs = 1; col = 1;
      #1 chk("R9 full duplex deferral ignores carrier", 0, 0, 8'h00, 0, 0, 0, 0);
      @(negedge clk);
    end
    for (int i = 0; i < nb + len; i++) begin
      crs = 0; col = 0;
      sdata = 8'($urandom);
      serr  = ($urandom % 8 == 0);
      slast = (i == nb - 1);
      if (i == ab_at) begin
        if (!hd) begin crs = 1; col = 1; end
        else if ($urandom % 2) crs = 1;
        else col = 1;
      end
      #1;
      if (hd && i == ab_at) begin
        chk("R3 abort on carrier or collision", 0, 0, 8'h00, 0, 1, 0, 0);
        aborted = 1;
      end else if (i < nb) begin
        chk("R2 R7 R8 R9 frame byte", 1, serr, sdata, 1, 0, (i == nb - 1) && len == 0, 0);
      end else begin
        chk("R5 R6 R8 extension byte", 0, 1, tail_code(een, at, i - nb), 0, 0,
            i == nb + len - 1, 0);
      end
      @(negedge clk);
      if (aborted) break;
    end
    slast = 0; serr = 0;
    if (aborted) begin
      for (int k = 0; k < qa; k++) begin
        crs = 1; col = k[0]; start = (k == 0);
        #1 chk("R3 R4 held off after abort", 0, 0, 8'h00, 0, 0, 0, 0);
        @(negedge clk);
      end
      start = 0; crs = 0; col = 0;
      #1 chk("R4 first quiet cycle after abort", 0, 0, 8'h00, 0, 0, 0, 0);
      @(negedge clk);
    end
    crs = 0; col = 0;
    #1 chk("R4 R7 R11 idle after frame", 0, 0, 8'h00, 0, 0, 0, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; half = 1; crs = 0; col = 0; start = 0;
    ext_len = '0; ext_een = 0; ext_at = '0; sdata = 8'hA5; serr = 0; slast = 0;
    repeat (3) @(negedge clk);
    #1 chk("R10 reset state", 0, 0, 8'h00, 0, 0, 0, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1 chk("R10 R11 idle after reset", 0, 0, 8'h00, 0, 0, 0, 1);
    @(negedge clk);
    // directed corner cases
    run_frame(1, 4, 0, 0, 0, 3, -1, 0);   // R7 no tail
    run_frame(1, 3, 4, 0, 0, 0, -1, 0);   // R5 plain tail
    run_frame(1, 2, 5, 1, 0, 1, -1, 0);   // R6 error from first tail byte
    run_frame(1, 2, 4, 1, 2, 0, -1, 0);   // R6 error part way
    run_frame(1, 2, 3, 1, 9, 0, -1, 0);   // R6 error index beyond tail
    run_frame(1, 1, 0, 0, 0, 0, -1, 0);   // R8 single byte frame
    run_frame(1, 5, 2, 0, 0, 2, 0, 3);    // R3 abort on first byte
    run_frame(1, 3, 4, 1, 1, 0, 5, 2);    // R3 abort inside tail
    run_frame(1, 3, 2, 0, 0, 0, 2, 0);    // R4 quiet at once after abort
    run_frame(0, 4, 2, 1, 1, 0, 1, 0);    // R9 full duplex ignores collision
    run_frame(0, 2, 0, 0, 0, 0, 0, 0);    // R9
    // random mix
    for (int f = 0; f < 80; f++) begin
      int nb, len, at, ab;
      nb  = 1 + $urandom % 8;
      len = $urandom % 6;
      at  = $urandom % 6;
      ab  = ($urandom % 3 == 0) ? int'($urandom % (nb + len)) : -1;
      run_frame(($urandom % 4) != 0, nb, len, $urandom % 2, at, $urandom % 4, ab,
                $urandom % 4);
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule